// File: doc/BRIEF.md
# Shift-Right Instruction Execution Sequencer

This block carries out one instruction of an 8/16-bit accumulator processor: a logical shift right by one bit. The shift targets either the accumulator or a byte or word in memory. The surrounding core presents the opcode, up to two operand bytes, the direct page base, the X index, the accumulator and the status byte, and raises `start` for one cycle. The sequencer decodes the addressing form and forms the effective address. It then walks through the exact number of bus cycles that form takes, using a simple synchronous memory port, and reports completion with a one-cycle `done` pulse.

Results are held on `acc_out` and `flags_out` from the cycle after `done` until the next instruction completes. `instr_len` tells the core how far to advance its program counter. The M bit of the incoming status byte sets the operand width:

- When M is set, the operand is one byte wide.
- When M is clear, the operand is a 16-bit word. Memory forms then spend two more cycles on the upper byte.

An unknown opcode is flagged at once and changes nothing.

Top module: `shr_exec`

## Requirements
- R1: Only the opcodes 0x4A, 0x46, 0x56, 0x4E and 0x5E are accepted. When any other opcode is presented with `start` while idle, `illegal` is high in that same cycle, `busy` stays low, and `acc_out`/`flags_out` keep their values.
- R2: The result is the operand shifted one place toward bit 0 with a zero entering the top bit. In 8-bit accumulator form, bits 15:8 of the accumulator pass through unchanged. Memory forms leave the accumulator unchanged.
- R3: The carry result (status bit 0) is bit 0 of the operand before the shift.
- R4: Status bits are N=7, V=6, M=5, X=4, D=3, I=2, Z=1, C=0. After completion, N is 0 and Z is 1 exactly when the result is zero over the active width (8 bits if M=1, 16 if M=0). Bits 6..2 equal the incoming status.
- R5: In 8-bit width the totals are 2 cycles for 0x4A, 5 for 0x46, 6 for 0x56, 6 for 0x4E and 7 for 0x5E. The cycle in which `start` is accepted counts as cycle 1.
- R6: The direct page forms (0x46, 0x56) take one extra cycle when `dp_reg[7:0]` is nonzero.
- R7: With M=0, every memory form takes two extra cycles. Its bus order is: read at EA, read at EA+1, write the high result byte at EA+1, write the low result byte at EA. With M=1 the order is a single read at EA, then a single write at EA.
- R8: The effective address wraps at 16 bits and is formed as follows:
  - 0x4E: {op_hi, op_lo}
  - 0x5E: {op_hi, op_lo} + X
  - 0x46: D + op_lo
  - 0x56: D + op_lo + X
- R9: `done` is high for exactly one cycle, the last cycle of the instruction. The new `acc_out`/`flags_out` are visible from the next cycle, and `busy` is then low.
- R10: During `done`, `instr_len` shows the instruction length in bytes: 1 for 0x4A, 2 for the direct page forms and 3 for the absolute forms. Otherwise it is 0.
- R11: Reads have one cycle of latency, with data on `mem_rdata` the cycle after `mem_rd`. The port never reads and writes in the same cycle and is silent while idle. `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an instruction (taken when idle) |
| opcode | input | 8 | Instruction opcode |
| op_lo | input | 8 | First operand byte |
| op_hi | input | 8 | Second operand byte |
| dp_reg | input | 16 | Direct page base |
| x_reg | input | 16 | X index |
| acc_in | input | 16 | Accumulator value |
| flags_in | input | 8 | Status byte |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, one cycle after `mem_rd` |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Last cycle of the instruction |
| illegal | output | 1 | Unknown opcode presented with `start` |
| instr_len | output | 2 | Instruction length during `done` |
| acc_out | output | 16 | Accumulator after the last instruction |
| flags_out | output | 8 | Status byte after the last instruction |

## Verification
The hardest situation to reach from the ports is a 16-bit memory operand in a direct page indexed form. In that case the low byte of D must be nonzero and D + op_lo + X must cross the top of the address space, so that the extra cycles of R6 and R7 stack on top of a wrapped address. Random stimulus picks D's low byte as zero or nonzero with equal odds and draws the M bit, so every form meets both timing adders. Directed vectors force the wrap cases, the zero and carry corners of both widths, and a `start` held high with an unknown opcode throughout a running instruction.

// File: rtl/shr_pkg.sv
// Package: shared types and the cycle-count rule for the shift-right sequencer.
// Assumes a 16-bit address space and status bit M at position 5.
package shr_pkg;

    typedef enum logic [2:0] {
        AM_ACC  = 3'd0,
        AM_ABS  = 3'd1,
        AM_DP   = 3'd2,
        AM_ABSX = 3'd3,
        AM_DPX  = 3'd4
    } am_t;

    localparam int FLAG_C = 0;
    localparam int FLAG_Z = 1;
    localparam int FLAG_M = 5;
    localparam int FLAG_N = 7;

    // Total cycles of one instruction, counting the start cycle as cycle 1.
    function automatic int cycle_total(am_t m, logic wide, logic dp_nz);
        int n;
        case (m)
            AM_ACC:  n = 2;
            AM_ABS:  n = 6;
            AM_DP:   n = 5;
            AM_ABSX: n = 7;
            default: n = 6;
        endcase
        if (m != AM_ACC && wide)
            n = n + 2;
        if ((m == AM_DP || m == AM_DPX) && dp_nz)
            n = n + 1;
        return n;
    endfunction

endpackage

// File: rtl/shr_decode.sv
// Opcode decoder: maps the five accepted opcodes to an addressing form and
// an instruction length. Any other value yields legal = 0 and length 0.
module shr_decode
    import shr_pkg::*;
(
    input  logic [7:0] opcode,
    output am_t        mode,
    output logic       legal,
    output logic [1:0] len
);

    // Purpose: table lookup from opcode to form and length.
    always_comb begin
        mode  = AM_ACC;
        legal = 1'b1;
        len   = 2'd0;
        case (opcode)
            8'h4A: begin mode = AM_ACC;  len = 2'd1; end
            8'h4E: begin mode = AM_ABS;  len = 2'd3; end
            8'h46: begin mode = AM_DP;   len = 2'd2; end
            8'h5E: begin mode = AM_ABSX; len = 2'd3; end
            8'h56: begin mode = AM_DPX;  len = 2'd2; end
            default: legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/shr_agen.sv
// Effective address generator. All sums wrap at AW bits; no bank handling.
// Assumes AW >= 16 so that {op_hi, op_lo} fits.
module shr_agen
    import shr_pkg::*;
#(
    parameter int AW = 16
) (
    input  am_t           mode,
    input  logic [7:0]    op_lo,
    input  logic [7:0]    op_hi,
    input  logic [AW-1:0] dp_reg,
    input  logic [AW-1:0] x_reg,
    output logic [AW-1:0] ea
);

    localparam int PAD = AW - 8;

    logic [AW-1:0] abs_base;
    logic [AW-1:0] dp_base;

    assign abs_base = AW'({op_hi, op_lo});
    assign dp_base  = dp_reg + {{PAD{1'b0}}, op_lo};

    // Purpose: pick base and optional X offset by form.
    always_comb begin
        case (mode)
            AM_ABS:  ea = abs_base;
            AM_ABSX: ea = abs_base + x_reg;
            AM_DP:   ea = dp_base;
            AM_DPX:  ea = dp_base + x_reg;
            default: ea = '0;
        endcase
    end

endmodule

// File: rtl/shr_alu.sv
// Shift unit: one-place logical right shift with zero and carry results.
// In narrow width only the low byte shifts; the high byte passes through.
module shr_alu #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] opnd,
    input  logic          wide,
    output logic [DW-1:0] res,
    output logic          z,
    output logic          c
);

    localparam int HB = DW / 2;

    // Purpose: form the shifted value and its flags for the active width.
    always_comb begin
        c = opnd[0];
        if (wide) begin
            res = opnd >> 1;
            z   = (res == '0);
        end else begin
            res = {opnd[DW-1:HB], 1'b0, opnd[HB-1:1]};
            z   = (res[HB-1:0] == '0);
        end
    end

endmodule

// File: rtl/shr_exec.sv
// Shift-right execution sequencer. Accepts one instruction on start while
// idle, counts its cycles, drives a synchronous memory port (read data one
// cycle after the strobe) and commits accumulator and status on done.
// Assumes inputs other than mem_rdata need only be valid in the start cycle.
module shr_exec
    import shr_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [7:0]    opcode,
    input  logic [7:0]    op_lo,
    input  logic [7:0]    op_hi,
    input  logic [AW-1:0] dp_reg,
    input  logic [AW-1:0] x_reg,
    input  logic [15:0]   acc_in,
    input  logic [7:0]    flags_in,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata,
    output logic          busy,
    output logic          done,
    output logic          illegal,
    output logic [1:0]    instr_len,
    output logic [15:0]   acc_out,
    output logic [7:0]    flags_out
);

    am_t           dec_mode;
    logic          dec_legal;
    logic [1:0]    dec_len;
    logic [AW-1:0] dec_ea;
    logic          dec_wide;
    logic [CW-1:0] dec_total;
    logic          accept;

    logic          busy_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] total_q;
    am_t           mode_q;
    logic          wide_q;
    logic [1:0]    len_q;
    logic [AW-1:0] ea_q;
    logic [15:0]   opnd_q;
    logic [15:0]   acc_q;
    logic [7:0]    fl_q;
    logic [15:0]   acc_out_q;
    logic [7:0]    flags_out_q;

    logic [15:0]   alu_res;
    logic          alu_z;
    logic          alu_c;

    logic          is_mem;
    logic          last;
    logic [CW-1:0] rd_lo_at;
    logic          rd_lo, rd_hi, wr_lo, wr_hi, cap_lo, cap_hi;

    shr_decode u_dec (
        .opcode (opcode),
        .mode   (dec_mode),
        .legal  (dec_legal),
        .len    (dec_len)
    );

    shr_agen #(.AW(AW)) u_agen (
        .mode   (dec_mode),
        .op_lo  (op_lo),
        .op_hi  (op_hi),
        .dp_reg (dp_reg),
        .x_reg  (x_reg),
        .ea     (dec_ea)
    );

    shr_alu #(.DW(16)) u_alu (
        .opnd (opnd_q),
        .wide (wide_q),
        .res  (alu_res),
        .z    (alu_z),
        .c    (alu_c)
    );

    assign dec_wide  = ~flags_in[FLAG_M];
    assign dec_total = CW'(cycle_total(dec_mode, dec_wide, dp_reg[7:0] != 8'd0));
    assign accept    = start && !busy_q && dec_legal;

    // Purpose: bus slot decode, counted back from the last cycle.
    always_comb begin
        is_mem   = (mode_q != AM_ACC);
        last     = busy_q && (cnt_q == total_q);
        rd_lo_at = total_q - (wide_q ? CW'(4) : CW'(2));
        rd_lo    = busy_q && is_mem && (cnt_q == rd_lo_at);
        cap_lo   = busy_q && is_mem && (cnt_q == rd_lo_at + CW'(1));
        rd_hi    = busy_q && is_mem && wide_q && (cnt_q == total_q - CW'(3));
        cap_hi   = busy_q && is_mem && wide_q && (cnt_q == total_q - CW'(2));
        wr_hi    = busy_q && is_mem && wide_q && (cnt_q == total_q - CW'(1));
        wr_lo    = busy_q && is_mem && last;
    end

    // Purpose: drive the memory port from the active slot.
    always_comb begin
        mem_rd    = rd_lo || rd_hi;
        mem_wr    = wr_lo || wr_hi;
        mem_addr  = '0;
        mem_wdata = 8'd0;
        if (rd_hi || wr_hi)
            mem_addr = ea_q + AW'(1);
        else if (rd_lo || wr_lo)
            mem_addr = ea_q;
        if (wr_hi)
            mem_wdata = alu_res[15:8];
        else if (wr_lo)
            mem_wdata = alu_res[7:0];
    end

    // Purpose: sequencer state, operand capture and commit of results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q      <= 1'b0;
            cnt_q       <= '0;
            total_q     <= '0;
            mode_q      <= AM_ACC;
            wide_q      <= 1'b0;
            len_q       <= 2'd0;
            ea_q        <= '0;
            opnd_q      <= 16'd0;
            acc_q       <= 16'd0;
            fl_q        <= 8'd0;
            acc_out_q   <= 16'd0;
            flags_out_q <= 8'd0;
        end else if (accept) begin
            busy_q  <= 1'b1;
            cnt_q   <= CW'(2);
            total_q <= dec_total;
            mode_q  <= dec_mode;
            wide_q  <= dec_wide;
            len_q   <= dec_len;
            ea_q    <= dec_ea;
            opnd_q  <= acc_in;
            acc_q   <= acc_in;
            fl_q    <= flags_in;
        end else if (busy_q) begin
            if (cap_lo)
                opnd_q[7:0] <= mem_rdata;
            if (cap_hi)
                opnd_q[15:8] <= mem_rdata;
            if (last) begin
                busy_q      <= 1'b0;
                flags_out_q <= {1'b0, fl_q[6:2], alu_z, alu_c};
                acc_out_q   <= is_mem ? acc_q : alu_res;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    assign busy      = busy_q;
    assign done      = last;
    assign illegal   = start && !busy_q && !dec_legal;
    assign instr_len = last ? len_q : 2'd0;
    assign acc_out   = acc_out_q;
    assign flags_out = flags_out_q;

endmodule

// File: rtl/shr_exec_chk.sv
// Checker for shr_exec: temporal properties on its ports, bound below.
module shr_exec_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic        illegal,
    input logic        mem_rd,
    input logic        mem_wr,
    input logic [15:0] acc_out,
    input logic [7:0]  flags_out
);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    // R11
    bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd && !mem_wr && !done));

    // R4
    neg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !flags_out[7]);

    // R1
    illegal_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> !busy);

    // R1
    hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> ($stable(flags_out) && $stable(acc_out)));

endmodule

bind shr_exec shr_exec_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .illegal   (illegal),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .acc_out   (acc_out),
    .flags_out (flags_out)
);

// File: tb/shr_exec_bench.sv
`timescale 1ns/1ps
module shr_exec_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00, op_lo = 8'h00, op_hi = 8'h00, flags_in = 8'h00;
    logic [15:0] dp_reg = 16'h0, x_reg = 16'h0, acc_in = 16'h0;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;
    logic        busy, done, illegal;
    logic [1:0]  instr_len;
    logic [15:0] acc_out;
    logic [7:0]  flags_out;

    int vectors = 0;
    int miscompares = 0;

    // Bench memory: two chosen bytes at the expected EA, hash elsewhere.
    logic [15:0] cur_ea = 16'h0;
    logic [7:0]  m_lo = 8'h0, m_hi = 8'h0;
    int          rd_n = 0, wr_n = 0;
    logic [15:0] rd_a [4];
    logic [15:0] wr_a [4];
    logic [7:0]  wr_d [4];

    always #2.5 clk = ~clk;

    shr_exec u_shr_exec (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .op_lo(op_lo), .op_hi(op_hi), .dp_reg(dp_reg), .x_reg(x_reg),
        .acc_in(acc_in), .flags_in(flags_in), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .illegal(illegal),
        .instr_len(instr_len), .acc_out(acc_out), .flags_out(flags_out)
    );

    function automatic logic [7:0] mem_val(logic [15:0] a);
        if (a == cur_ea) return m_lo;
        if (a == cur_ea + 16'd1) return m_hi;
        return a[7:0] ^ a[15:8] ^ 8'hC3;
    endfunction

    always @(posedge clk) begin
        if (mem_rd) begin
            mem_rdata <= mem_val(mem_addr);
            if (rd_n < 4) rd_a[rd_n] = mem_addr;
            rd_n = rd_n + 1;
        end
        if (mem_wr) begin
            if (wr_n < 4) begin wr_a[wr_n] = mem_addr; wr_d[wr_n] = mem_wdata; end
            wr_n = wr_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit is_legal(logic [7:0] op);
        return op == 8'h4A || op == 8'h4E || op == 8'h46 || op == 8'h5E || op == 8'h56;
    endfunction

    function automatic int exp_cycles(logic [7:0] op, bit wide, logic [15:0] d);
        int n;
        bit dpf;
        dpf = (op == 8'h46 || op == 8'h56);
        case (op)
            8'h4A: n = 2; 8'h4E: n = 6; 8'h46: n = 5; 8'h5E: n = 7; default: n = 6;
        endcase
        if (op != 8'h4A && wide) n += 2;
        if (dpf && d[7:0] != 8'd0) n += 1;
        return n;
    endfunction

    function automatic logic [15:0] exp_ea(logic [7:0] op, logic [7:0] lo, logic [7:0] hi,
                                           logic [15:0] d, logic [15:0] x);
        case (op)
            8'h4E: return {hi, lo};
            8'h5E: return {hi, lo} + x;
            8'h46: return d + {8'h0, lo};
            default: return d + {8'h0, lo} + x;
        endcase
    endfunction

    function automatic logic [1:0] exp_len(logic [7:0] op);
        if (op == 8'h4A) return 2'd1;
        if (op == 8'h46 || op == 8'h56) return 2'd2;
        return 2'd3;
    endfunction

    task automatic run_one(input logic [7:0] op, input logic [7:0] lo, input logic [7:0] hi,
                           input logic [15:0] d, input logic [15:0] x, input logic [15:0] a,
                           input logic [7:0] fl, input logic [7:0] dlo, input logic [7:0] dhi,
                           input bit hold);
        logic [15:0] pre_acc, src, res, exp_acc;
        logic [7:0]  pre_fl, exp_fl;
        bit          wide, mem, z, c;
        int          cyc, ncyc;
        pre_acc = acc_out;
        pre_fl  = flags_out;
        opcode = op; op_lo = lo; op_hi = hi; dp_reg = d; x_reg = x;
        acc_in = a; flags_in = fl; start = 1'b1;
        if (!is_legal(op)) begin
            #0.1;
            chk(illegal === 1'b1, "R1 illegal flag", {31'd0, illegal}, 32'd1);
            @(posedge clk); @(negedge clk);
            start = 1'b0;
            chk(busy === 1'b0, "R1 busy after illegal", {31'd0, busy}, 32'd0);
            chk(acc_out === pre_acc && flags_out === pre_fl, "R1 state kept",
                {8'd0, flags_out, acc_out}, {8'd0, pre_fl, pre_acc});
            return;
        end
        wide = !fl[5];
        mem  = (op != 8'h4A);
        cur_ea = mem ? exp_ea(op, lo, hi, d, x) : 16'h0;
        m_lo = dlo; m_hi = dhi;
        rd_n = 0; wr_n = 0;
        ncyc = exp_cycles(op, wide, d);
        #0.1;
        chk(illegal === 1'b0, "R1 legal opcode", {31'd0, illegal}, 32'd0);
        @(posedge clk); @(negedge clk);
        cyc = 2;
        if (hold) opcode = 8'hFF; else start = 1'b0;
        while (!done && cyc < 20) begin
            if (hold) chk(illegal === 1'b0, "R11 start ignored while busy", {31'd0, illegal}, 32'd0);
            @(posedge clk); @(negedge clk);
            cyc++;
        end
        chk(cyc == ncyc, "R5 R6 R7 cycle count", cyc, ncyc);
        chk(instr_len === exp_len(op), "R10 length", {30'd0, instr_len}, {30'd0, exp_len(op)});
        start = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0, "R9 single done", {30'd0, busy, done}, 32'd0);
        chk(instr_len === 2'd0, "R10 length outside done", {30'd0, instr_len}, 32'd0);
        src = mem ? {dhi, dlo} : a;
        c = src[0];
        if (wide) begin
            res = src >> 1;
            z = (res == 16'd0);
        end else begin
            res = {src[15:8], 1'b0, src[7:1]};
            z = (res[7:0] == 8'd0);
        end
        exp_acc = mem ? a : res;
        exp_fl  = {1'b0, fl[6:2], z, c};
        chk(acc_out === exp_acc, "R2 accumulator", {16'd0, acc_out}, {16'd0, exp_acc});
        chk(flags_out[0] === c, "R3 carry", {31'd0, flags_out[0]}, {31'd0, c});
        chk(flags_out === exp_fl, "R4 status", {24'd0, flags_out}, {24'd0, exp_fl});
        if (!mem) begin
            chk(rd_n == 0 && wr_n == 0, "R11 no bus in accumulator form", rd_n * 16 + wr_n, 0);
        end else if (wide) begin
            chk(rd_n == 2 && wr_n == 2, "R7 access count", rd_n * 16 + wr_n, 32'h22);
            if (rd_n == 2 && wr_n == 2) begin
                chk(rd_a[0] === cur_ea && rd_a[1] === cur_ea + 16'd1, "R8 read addresses",
                    {rd_a[0], rd_a[1]}, {cur_ea, cur_ea + 16'd1});
                chk(wr_a[0] === cur_ea + 16'd1 && wr_a[1] === cur_ea, "R7 write order",
                    {wr_a[0], wr_a[1]}, {cur_ea + 16'd1, cur_ea});
                chk(wr_d[0] === res[15:8] && wr_d[1] === res[7:0], "R2 written word",
                    {16'd0, wr_d[0], wr_d[1]}, {16'd0, res});
            end
        end else begin
            chk(rd_n == 1 && wr_n == 1, "R7 access count", rd_n * 16 + wr_n, 32'h11);
            if (rd_n == 1 && wr_n == 1) begin
                chk(rd_a[0] === cur_ea && wr_a[0] === cur_ea, "R8 address",
                    {rd_a[0], wr_a[0]}, {cur_ea, cur_ea});
                chk(wr_d[0] === res[7:0], "R2 written byte", {24'd0, wr_d[0]}, {24'd0, res[7:0]});
            end
        end
    endtask

    initial begin
        #(160000 * 5);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [7:0] ops [5];
        void'($urandom(32'h1F2E3D4C));
        ops[0] = 8'h4A; ops[1] = 8'h4E; ops[2] = 8'h46; ops[3] = 8'h5E; ops[4] = 8'h56;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0 && acc_out === 16'd0 && flags_out === 8'd0,
            "R9 reset state", {8'd0, flags_out, acc_out}, 32'd0);
        // Directed corners.
        run_one(8'h4A, 8'h00, 8'h00, 16'h0, 16'h0, 16'hAB01, 8'h7C, 8'h0, 8'h0, 0); // R3 R4 8-bit zero
        run_one(8'h4A, 8'h00, 8'h00, 16'h0, 16'h0, 16'h8000, 8'hDF, 8'h0, 8'h0, 0); // R2 16-bit
        run_one(8'h46, 8'h10, 8'h00, 16'h1200, 16'h0, 16'h1234, 8'hFF, 8'hFF, 8'h00, 0); // R6 dp low zero
        run_one(8'h46, 8'h10, 8'h00, 16'h1201, 16'h0, 16'h1234, 8'hFF, 8'h80, 8'h00, 0); // R6 nonzero
        run_one(8'h56, 8'h20, 8'h00, 16'hFFF1, 16'h0005, 16'h0, 8'hC0, 8'h01, 8'h00, 0); // R8 wrap, wide
        run_one(8'h5E, 8'hFF, 8'hFF, 16'h0, 16'h0002, 16'h0, 8'h20, 8'h02, 8'h7E, 0); // R8 wrap
        run_one(8'h4E, 8'h34, 8'h12, 16'h0, 16'h0, 16'h5555, 8'h00, 8'h01, 8'h00, 0);  // R4 16-bit zero
        run_one(8'h4B, 8'h00, 8'h00, 16'h0, 16'h0, 16'h0, 8'h00, 8'h0, 8'h0, 0);      // R1
        run_one(8'h56, 8'h05, 8'h00, 16'h0300, 16'h0010, 16'h0, 8'h24, 8'h33, 8'h00, 1); // R11 hold
        // Random mix.
        for (int i = 0; i < 400; i++) begin
            logic [7:0] op;
            logic [15:0] d;
            logic [7:0] fl;
            op = ($urandom_range(0, 9) == 0) ? 8'($urandom) : ops[$urandom_range(0, 4)];
            d  = 16'($urandom);
            if ($urandom_range(0, 1) == 0) d[7:0] = 8'h00;
            fl = 8'($urandom);
            run_one(op, 8'($urandom), 8'($urandom), d, 16'($urandom), 16'($urandom), fl,
                    8'($urandom_range(0, 3) == 0 ? 0 : $urandom),
                    8'($urandom_range(0, 3) == 0 ? 0 : $urandom), ($urandom_range(0, 7) == 0));
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule